// File: doc/BRIEF.md
# Reset Cause and Start-up Sequencer

This block sits between the reset sources of a small USB microcontroller and its CPU core. It accepts three reset sources: a power-on pulse, a watchdog timeout pulse and a USB bus reset indication. It holds the CPU in reset for a start-up interval and records which source fired in a sticky cause byte. Firmware clears that byte by writing ones. A USB bus reset is only recorded and does not reset the CPU.

The length of the start-up interval is not fixed. It depends on a board strap input and on the sticky power-on bit. After power-on, if the strap is high and the USB lines are idle, the block first parks the part in suspend. It leaves suspend when the lines show a K state or SE0, or when a bus reset is signalled. The strap input and both data lines are synchronized before use. Both interval lengths are parameters counted in core clock cycles, nominally 1536 cycles (128 µs) and 1,152,000 cycles (96 ms) at 12 MHz.

Top module: `reset_startup_seq`

## Requirements
- R1: After the asynchronous reset, `cpu_rst`, `gpio_force_in` and `suspended` are 0 and `cause_q` reads 0x00.
- R2: One cycle after `por_pulse` is sampled high, `cpu_rst` and `gpio_force_in` are 1, and they stay 1 while it remains high. The pulse sets cause bit 4 and clears cause bits 5 and 6.
- R3: When `por_pulse` falls while the synchronized strap is 1 and the lines are idle (`usb_dm`=1, `usb_dp`=0), the block enters suspend. In suspend, `suspended`=1 and `cpu_rst`=1 until a wake condition occurs.
- R4: Suspend ends on a K state (`usb_dp`=1, `usb_dm`=0), on SE0 (both lines 0) or on a `usb_bus_rst` pulse. The wake is followed by the start-up interval.
- R5: The interval is SHORT_CYC if the synchronized strap is 1, else LONG_CYC if cause bit 4 is 1, else SHORT_CYC. `cpu_rst` falls after exactly interval+1 clock edges, counted from the edge that samples the releasing event (falling power-on, watchdog pulse or bus reset pulse). For a wake by line state, two synchronizer edges are added.
- R6: A `wdog_pulse` holds the CPU through the interval chosen by R5. It sets cause bit 6, leaves bits 4 and 5 unchanged and does not raise `gpio_force_in`.
- R7: A `usb_bus_rst` pulse while the CPU runs sets cause bit 5 and leaves `cpu_rst` at 0.
- R8: A write with `cause_wr_en`=1 clears each cause bit whose `cause_wr_data` bit is 1. Bits written 0 keep their value.
- R9: A cause event in the same cycle as a clearing write of its bit wins: the bit ends up 1.
- R10: `gpio_force_in` falls in the same cycle that `cpu_rst` falls after a power-on start-up.
- R11: Cause bits 0 to 3 and bit 7 always read 0, whatever is written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset of the block's registers |
| por_pulse | input | 1 | Power-on event, high while the supply is below its trip point |
| wdog_pulse | input | 1 | Watchdog timeout, one-cycle pulse |
| usb_bus_rst | input | 1 | USB bus reset seen, one-cycle pulse |
| strap_in | input | 1 | Board strap selecting resonator start-up behaviour (asynchronous) |
| usb_dp | input | 1 | USB D+ level (asynchronous) |
| usb_dm | input | 1 | USB D- level (asynchronous) |
| cause_wr_en | input | 1 | Write strobe for the cause byte |
| cause_wr_data | input | 8 | Write-one-to-clear mask |
| cpu_rst | output | 1 | Holds the CPU core in reset |
| gpio_force_in | output | 1 | Forces GPIO ports to high-impedance input |
| suspended | output | 1 | Part parked in suspend, waiting for USB activity |
| cause_q | output | 8 | Reset cause byte: bit 4 power-on, bit 5 bus reset, bit 6 watchdog |

## Verification
A table of power-on cases sweeps the strap and the three line states (idle, SE0, K). This separates the suspend entry, which needs both the strap and idle lines, from the plain start-up paths, and a long versus short count shows which delay rule applied. Suspend is then left by each of the three wake conditions, and once with the strap lowered while suspended, which must switch the wake to the long interval. Watchdog resets are run with the power-on bit set, with it cleared and with the strap high, which together cover all three branches of the selection rule. Cause-byte writes test clearing, the spare bits and a set that collides with a clear.

// File: rtl/rsq_pkg.sv
package rsq_pkg;
  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_HOLD  = 2'd1,
    ST_SUSP  = 2'd2,
    ST_DELAY = 2'd3
  } rsq_state_e;

  localparam int unsigned POS_POR = 4;
  localparam int unsigned POS_USB = 5;
  localparam int unsigned POS_WDG = 6;
  localparam logic [7:0]  CAUSE_MASK = (8'd1 << POS_POR) | (8'd1 << POS_USB) | (8'd1 << POS_WDG);
endpackage

// File: rtl/rsq_sync.sv
module rsq_sync #(
  parameter int unsigned W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic meta_q, sync_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= 1'b0;
        sync_q <= 1'b0;
      end else begin
        meta_q <= d[i];
        sync_q <= meta_q;
      end
    end
    assign q[i] = sync_q;
  end
endmodule

// File: rtl/rsq_cause.sv
module rsq_cause
  import rsq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       set_por,
  input  logic       set_usb,
  input  logic       set_wdg,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic [7:0] q
);
  logic [7:0] q_d, clr_mask, set_mask;

  always_comb begin
    clr_mask = wr_en ? wr_data : 8'h00;
    if (set_por) clr_mask = clr_mask | CAUSE_MASK;   // power-on wipes older causes
    set_mask = 8'h00;
    set_mask[POS_POR] = set_por;
    set_mask[POS_USB] = set_usb;
    set_mask[POS_WDG] = set_wdg;
    q_d = ((q & ~clr_mask) | set_mask) & CAUSE_MASK; // set beats clear
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 8'h00;
    else        q <= q_d;
  end

  p_por_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
    set_por |=> q[POS_POR]);
  p_wdg_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (set_wdg && !set_por) |=> (q[POS_WDG] && (q[POS_POR] == $past(q[POS_POR]) || $past(wr_en))));
  p_w1c_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[POS_POR] && !set_por) |=> !q[POS_POR]);
  p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (set_usb && wr_en && wr_data[POS_USB]) |=> q[POS_USB]);
endmodule

// File: rtl/rsq_delay.sv
module rsq_delay #(
  parameter int unsigned SHORT_CYC = 1536,
  parameter int unsigned LONG_CYC  = 1152000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic use_long,
  input  logic count_en,
  output logic done
);
  localparam int unsigned CW = (LONG_CYC > 1) ? $clog2(LONG_CYC) : 1;
  localparam logic [CW-1:0] SHORT_LD = CW'(SHORT_CYC - 1);
  localparam logic [CW-1:0] LONG_LD  = CW'(LONG_CYC - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)                           cnt_d = use_long ? LONG_LD : SHORT_LD;
    else if (count_en && cnt_q != '0)   cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign done = (cnt_q == '0);

  p_cnt_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LONG_LD);
  p_cnt_moves_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (count_en && !load && !done) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/reset_startup_seq.sv
module reset_startup_seq
  import rsq_pkg::*;
#(
  parameter int unsigned SHORT_CYC = 1536,
  parameter int unsigned LONG_CYC  = 1152000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       por_pulse,
  input  logic       wdog_pulse,
  input  logic       usb_bus_rst,
  input  logic       strap_in,
  input  logic       usb_dp,
  input  logic       usb_dm,
  input  logic       cause_wr_en,
  input  logic [7:0] cause_wr_data,
  output logic       cpu_rst,
  output logic       gpio_force_in,
  output logic       suspended,
  output logic [7:0] cause_q
);
  rsq_state_e state_q, state_d;
  logic       gpio_q, gpio_d;
  logic [2:0] sync_q;
  logic       strap_s, dp_s, dm_s;
  logic       lines_idle, line_k, line_se0;
  logic       dly_load, dly_long, dly_en, dly_done;

  rsq_sync #(.W(3)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    ({strap_in, usb_dp, usb_dm}),
    .q    (sync_q)
  );
  assign {strap_s, dp_s, dm_s} = sync_q;

  assign lines_idle = dm_s && !dp_s;
  assign line_k     = dp_s && !dm_s;
  assign line_se0   = !dp_s && !dm_s;

  // strap high -> short; else sticky power-on bit -> long; else short
  assign dly_long = !strap_s && cause_q[POS_POR];
  assign dly_en   = (state_q == ST_DELAY);

  always_comb begin
    state_d  = state_q;
    gpio_d   = gpio_q;
    dly_load = 1'b0;
    if (por_pulse) begin
      state_d = ST_HOLD;
      gpio_d  = 1'b1;
    end else if (wdog_pulse) begin
      state_d  = ST_DELAY;
      dly_load = 1'b1;
    end else begin
      unique case (state_q)
        ST_HOLD: begin
          if (strap_s && lines_idle) begin
            state_d = ST_SUSP;
          end else begin
            state_d  = ST_DELAY;
            dly_load = 1'b1;
          end
        end
        ST_SUSP: begin
          if (line_k || line_se0 || usb_bus_rst) begin
            state_d  = ST_DELAY;
            dly_load = 1'b1;
          end
        end
        ST_DELAY: begin
          if (dly_done) begin
            state_d = ST_RUN;
            gpio_d  = 1'b0;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_RUN;
      gpio_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      gpio_q  <= gpio_d;
    end
  end

  rsq_delay #(.SHORT_CYC(SHORT_CYC), .LONG_CYC(LONG_CYC)) u_delay (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (dly_load),
    .use_long(dly_long),
    .count_en(dly_en),
    .done    (dly_done)
  );

  rsq_cause u_cause (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_por(por_pulse),
    .set_usb(usb_bus_rst),
    .set_wdg(wdog_pulse),
    .wr_en  (cause_wr_en),
    .wr_data(cause_wr_data),
    .q      (cause_q)
  );

  assign cpu_rst       = (state_q != ST_RUN);
  assign suspended     = (state_q == ST_SUSP);
  assign gpio_force_in = gpio_q;

  p_por_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    por_pulse |=> (cpu_rst && gpio_force_in));
  p_susp_stays_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (suspended && !por_pulse && !wdog_pulse && !usb_bus_rst && lines_idle) |=> suspended);
  p_wake_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (suspended && !por_pulse && (line_k || line_se0 || usb_bus_rst)) |=> (!suspended && cpu_rst));
  p_bus_rst_soft_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (usb_bus_rst && !por_pulse && !wdog_pulse && !cpu_rst) |=> !cpu_rst);
  p_gpio_in_reset_r10: assert property (@(posedge clk) disable iff (!rst_n)
    gpio_force_in |-> cpu_rst);
  p_spare_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (cause_q & ~CAUSE_MASK) == 8'h00);
endmodule

// File: tb/reset_startup_seq_test.sv
module reset_startup_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int SHORT = 20;
  localparam int LONG  = 60;

  // {strap, dp, dm, expect_suspend, expect_long}
  localparam logic [4:0] VEC [6] = '{
    5'b0_01_0_1,
    5'b1_01_1_0,
    5'b1_00_0_0,
    5'b1_10_0_0,
    5'b0_00_0_1,
    5'b0_10_0_1
  };

  logic clk = 1'b0;
  logic rst_n, por_pulse, wdog_pulse, usb_bus_rst, strap_in, usb_dp, usb_dm;
  logic cause_wr_en;
  logic [7:0] cause_wr_data;
  logic cpu_rst, gpio_force_in, suspended;
  logic [7:0] cause_q;
  int n_cmp = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  reset_startup_seq #(.SHORT_CYC(SHORT), .LONG_CYC(LONG)) uut (
    .clk(clk), .rst_n(rst_n), .por_pulse(por_pulse), .wdog_pulse(wdog_pulse),
    .usb_bus_rst(usb_bus_rst), .strap_in(strap_in), .usb_dp(usb_dp), .usb_dm(usb_dm),
    .cause_wr_en(cause_wr_en), .cause_wr_data(cause_wr_data),
    .cpu_rst(cpu_rst), .gpio_force_in(gpio_force_in), .suspended(suspended), .cause_q(cause_q)
  );

  task automatic check(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic tick(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  // counts rising edges until cpu_rst is seen low; one-cycle pulses dropped after first edge
  task automatic measure(output int n);
    n = 0;
    forever begin
      @(negedge clk);
      n++;
      wdog_pulse  = 1'b0;
      usb_bus_rst = 1'b0;
      if (!cpu_rst || n > 4*LONG) break;
    end
  endtask

  task automatic do_por();
    por_pulse = 1'b1;
    tick(3);
    check("R2 cpu_rst during power-on", cpu_rst, 1);
    check("R2 gpio_force_in during power-on", gpio_force_in, 1);
    check("R2 cause after power-on", cause_q, 8'h10);
    por_pulse = 1'b0;
  endtask

  task automatic wr_cause(logic [7:0] v);
    cause_wr_en = 1'b1; cause_wr_data = v;
    tick();
    cause_wr_en = 1'b0; cause_wr_data = 8'h00;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    int n;
    rst_n = 1'b0; por_pulse = 1'b0; wdog_pulse = 1'b0; usb_bus_rst = 1'b0;
    strap_in = 1'b0; usb_dp = 1'b0; usb_dm = 1'b1;
    cause_wr_en = 1'b0; cause_wr_data = 8'h00;
    tick(3);
    rst_n = 1'b1;
    tick(3);
    // R1 reset state
    check("R1 cpu_rst after reset", cpu_rst, 0);
    check("R1 gpio_force_in after reset", gpio_force_in, 0);
    check("R1 suspended after reset", suspended, 0);
    check("R1 cause after reset", cause_q, 0);

    // table of power-on cases: R3, R4, R5
    for (int i = 0; i < 6; i++) begin
      strap_in = VEC[i][4]; usb_dp = VEC[i][3]; usb_dm = VEC[i][2];
      tick(4);
      do_por();
      if (VEC[i][1]) begin
        tick(6);
        check("R3 suspended after idle power-on", suspended, 1);
        check("R3 cpu_rst in suspend", cpu_rst, 1);
        usb_dp = 1'b1; usb_dm = 1'b0;
        measure(n);
        check("R4 K wake short interval", n, SHORT + 3);
      end else begin
        measure(n);
        check("R5 power-on interval", n, (VEC[i][0] ? LONG : SHORT) + 1);
        check("R3 not suspended", suspended, 0);
      end
      check("R10 gpio_force_in released", gpio_force_in, 0);
    end

    // R4 wake on SE0
    strap_in = 1'b1; usb_dp = 1'b0; usb_dm = 1'b1;
    tick(4);
    do_por();
    tick(6);
    check("R3 suspended before SE0", suspended, 1);
    usb_dp = 1'b0; usb_dm = 1'b0;
    measure(n);
    check("R4 SE0 wake short interval", n, SHORT + 3);

    // R4 wake on bus reset pulse
    usb_dp = 1'b0; usb_dm = 1'b1;
    tick(4);
    do_por();
    tick(6);
    check("R3 suspended before bus reset", suspended, 1);
    usb_bus_rst = 1'b1;
    measure(n);
    check("R4 bus reset wake interval", n, SHORT + 1);
    check("R4 bus reset cause bit 5", cause_q, 8'h30);

    // R5 strap lowered while suspended -> long interval on wake
    tick(2);
    do_por();
    tick(6);
    strap_in = 1'b0;
    tick(4);
    check("R3 still suspended after strap drop", suspended, 1);
    usb_dp = 1'b1; usb_dm = 1'b0;
    measure(n);
    check("R5 strap low wake uses long", n, LONG + 3);
    usb_dp = 1'b0; usb_dm = 1'b1;
    tick(4);

    // R6 watchdog, strap low, power-on bit set -> long
    wdog_pulse = 1'b1;
    tick();
    wdog_pulse = 1'b0;
    check("R6 cpu_rst after watchdog", cpu_rst, 1);
    check("R6 gpio_force_in stays low", gpio_force_in, 0);
    measure(n);
    check("R6 R5 watchdog long interval", n + 1, LONG + 1);
    check("R6 watchdog cause", cause_q, 8'h50);

    // R8 / R11 write-one-to-clear
    wr_cause(8'h10);
    check("R8 clear power-on bit", cause_q, 8'h40);
    wr_cause(8'h00);
    check("R8 zero write keeps bits", cause_q, 8'h40);
    wr_cause(8'h8F);
    check("R11 spare bits read zero", cause_q, 8'h40);

    // R5 watchdog with power-on bit clear -> short
    wdog_pulse = 1'b1;
    measure(n);
    check("R5 watchdog short after clear", n, SHORT + 1);

    // R5 strap high -> short even with power-on bit set
    tick(2);
    strap_in = 1'b1;
    usb_dp = 1'b1; usb_dm = 1'b0;
    tick(4);
    do_por();
    measure(n);
    check("R5 strap high power-on short", n, SHORT + 1);
    wdog_pulse = 1'b1;
    measure(n);
    check("R5 strap high watchdog short", n, SHORT + 1);
    strap_in = 1'b0;
    tick(4);

    // R7 bus reset while running
    usb_bus_rst = 1'b1;
    tick();
    usb_bus_rst = 1'b0;
    tick(5);
    check("R7 cpu_rst stays low", cpu_rst, 0);
    check("R7 cause bit 5 set", cause_q, 8'h70);

    // R9 set wins over clear
    usb_bus_rst = 1'b1;
    wr_cause(8'h20);
    usb_bus_rst = 1'b0;
    check("R9 set beats clear", cause_q, 8'h70);
    wr_cause(8'h70);
    check("R8 clear all causes", cause_q, 8'h00);

    report();
  end
endmodule